// File: doc/BRIEF.md
# Programmable GPIO Port Bank

This block is a bank of general-purpose I/O ports sitting on a small synchronous register bus of an 8-bit microcontroller. Each port has a direction register, an output latch and a pull-up control register. From these the bank computes, for every pin, an output enable, an output value and an effective pull-up enable, which go to an external pad model. Pad input levels come back through a two-stage synchroniser. A single drive-strength control bit, common to the bank, selects weak or strong output drive.

Software reads a port's data address to get a mixed view: pins set as outputs return the value held in the output latch, and pins set as inputs return the synchronised pad level. Writes to the data address always land in the latch. The pad is driven only after the pin's direction bit is set to output. Each bit of a port's pull-up register serves a pair of adjacent pins. A pull-up acts only while the pin is an input. Register bits that have no storage behind them read as zero.

Address map (ADDR_W = 8, port p): data at 4p, direction at 4p+1, pull-up at 4p+2, and nothing at 4p+3. The drive-strength register is at DRV_ADDR (default 0xF0), with the control in bit 0.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every pad_oe, pad_out and pad_pu bit is 0, drive_weak is 0, rdata is 0, and every register reads back as 0.
- R2: Bit i of the direction register of port p (address 4p+1) drives pad_oe[p*PORT_W+i]. A 1 means output. The register reads back as written.
- R3: A write to the data address (4p) updates the output latch whatever the direction. pad_out equals the latch. A pin whose direction bit is 0 keeps pad_oe at 0 until its direction bit is written to 1.
- R4: Reading the data address returns, for each bit, the latch value if the pin is an output, and the synchronised pad level if it is an input. A pad change made before rising edge k shows up in rdata only from edge k+2 onward.
- R5: Bit k of a port's pull-up register (address 4p+2) covers pins 2k and 2k+1. pad_pu of a pin is 1 exactly when that bit is 1 and the pin's direction bit is 0.
- R6: Pull-up register bits at and above ceil(PORT_W/2), and drive register bits 7:1, always read as 0, and writing 1 to them has no effect.
- R7: Bit 0 of the register at DRV_ADDR drives drive_weak (1 = weak drive, 0 = strong drive) and reads back in rdata bit 0.
- R8: Any address other than the port registers and DRV_ADDR (including 4p+3 and ports beyond NUM_PORTS) reads as 0. Writes to such addresses change no pad output.
- R9: rdata is registered: it shows the register selected by the bus_addr sampled at the previous rising edge, and holds that value until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pad_in | input | NUM_PORTS*PORT_W | Pad levels seen from outside |
| pad_oe | output | NUM_PORTS*PORT_W | Per-pin output enable |
| pad_out | output | NUM_PORTS*PORT_W | Per-pin output value |
| pad_pu | output | NUM_PORTS*PORT_W | Per-pin effective pull-up enable |
| drive_weak | output | 1 | Weak drive select for the high-voltage outputs |

## Verification
The assertions assume the bus holds one address per cycle with no X on bus_we or bus_addr after reset, and that a write strobe stays high for exactly one cycle. The temporal checks compare the pad controls in the cycle after a write with the data sampled at that write. The stimulus applies every bus change and every pad change at the falling edge, and holds each write for one clock, so each write is a single sampled strobe. Pad inputs change only while the bus is idle or reading, so each synchroniser delay check sees exactly one transition.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

   localparam int DBUS_W = 8;

   typedef enum logic [1:0] {
      SEL_DATA = 2'd0,
      SEL_DIR  = 2'd1,
      SEL_PULL = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) stg_q[s] <= '0;
            else        stg_q[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) stg_q[s] <= '0;
            else        stg_q[s] <= stg_q[s-1];
         end
      end
   end

   assign q = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_pkg::*;
#(
   parameter int PORT_W    = 8,
   localparam int PULL_BITS = (PORT_W + 1) / 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_data,
   input  logic                 wr_dir,
   input  logic                 wr_pull,
   input  logic [PORT_W-1:0]    wdata_pins,
   input  logic [PULL_BITS-1:0] wdata_pull,
   input  logic [PORT_W-1:0]    pad_sync,
   input  reg_sel_e             rd_sel,
   output logic [DBUS_W-1:0]    rd_val,
   output logic [PORT_W-1:0]    pad_oe,
   output logic [PORT_W-1:0]    pad_out,
   output logic [PORT_W-1:0]    pad_pu
);

   logic [PORT_W-1:0]    latch_q;
   logic [PORT_W-1:0]    dir_q;
   logic [PULL_BITS-1:0] pull_q;
   logic [PORT_W-1:0]    pin_view;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         latch_q <= '0;
         dir_q   <= '0;
         pull_q  <= '0;
      end else begin
         if (wr_data) latch_q <= wdata_pins;
         if (wr_dir)  dir_q   <= wdata_pins;
         if (wr_pull) pull_q  <= wdata_pull;
      end
   end

   assign pad_oe  = dir_q;
   assign pad_out = latch_q;

   for (genvar i = 0; i < PORT_W; i++) begin : g_pin
      assign pad_pu[i]   = pull_q[i/2] & ~dir_q[i];
      assign pin_view[i] = dir_q[i] ? latch_q[i] : pad_sync[i];
   end

   always_comb begin
      rd_val = '0;
      case (rd_sel)
         SEL_DATA: rd_val[PORT_W-1:0]    = pin_view;
         SEL_DIR:  rd_val[PORT_W-1:0]    = dir_q;
         SEL_PULL: rd_val[PULL_BITS-1:0] = pull_q;
         default:  rd_val = '0;
      endcase
   end

   // R3
   latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_data |=> pad_out == $past(wdata_pins));

   // R2
   dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dir |=> pad_oe == $past(wdata_pins));

   // R8
   pads_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_data || wr_dir || wr_pull) |=>
         ($stable(pad_oe) && $stable(pad_out) && $stable(pad_pu)));

   // R5
   pu_input_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_pu & pad_oe) == '0);

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_pkg::*;
#(
   parameter int              NUM_PORTS   = 4,
   parameter int              PORT_W      = 8,
   parameter int              ADDR_W      = 8,
   parameter int              SYNC_STAGES = 2,
   parameter logic [7:0]      DRV_ADDR    = 8'hF0,
   localparam int             PIN_N       = NUM_PORTS * PORT_W,
   localparam int             PULL_BITS   = (PORT_W + 1) / 2,
   localparam int             PIDX_W      = ADDR_W - 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        rdata,
   input  logic [PIN_N-1:0]  pad_in,
   output logic [PIN_N-1:0]  pad_oe,
   output logic [PIN_N-1:0]  pad_out,
   output logic [PIN_N-1:0]  pad_pu,
   output logic              drive_weak
);

   if (PORT_W < 1 || PORT_W > DBUS_W) begin : g_bad_w
      $error("gpio_bank: PORT_W must be within 1..8");
   end
   if (ADDR_W < 3 || ADDR_W > 8) begin : g_bad_a
      $error("gpio_bank: ADDR_W must be within 3..8");
   end
   if (NUM_PORTS < 1 || 4 * NUM_PORTS > int'(DRV_ADDR)) begin : g_bad_n
      $error("gpio_bank: port registers overlap the drive register");
   end
   if (int'(DRV_ADDR) >= (1 << ADDR_W)) begin : g_bad_d
      $error("gpio_bank: DRV_ADDR outside the address space");
   end

   localparam logic [PIDX_W-1:0] NPORT_L = PIDX_W'(NUM_PORTS);
   localparam logic [ADDR_W-1:0] DRV_L   = ADDR_W'(DRV_ADDR);

   logic [PIDX_W-1:0] port_idx;
   reg_sel_e          sel;
   logic              port_hit;
   logic              drv_hit;
   logic              drv_q;
   logic [PIN_N-1:0]  pad_sync;
   logic [7:0]        rd_vals [NUM_PORTS];
   logic [7:0]        rd_mux;

   assign port_idx = bus_addr[ADDR_W-1:2];
   assign sel      = reg_sel_e'(bus_addr[1:0]);
   assign port_hit = (port_idx < NPORT_L) && (sel != SEL_NONE);
   assign drv_hit  = (bus_addr == DRV_L);

   gpio_sync #(
      .W      (PIN_N),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pad_sync)
   );

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic sel_me;
      assign sel_me = bus_we && port_hit && (port_idx == PIDX_W'(p));

      gpio_port #(
         .PORT_W (PORT_W)
      ) u_port (
         .clk        (clk),
         .rst_n      (rst_n),
         .wr_data    (sel_me && sel == SEL_DATA),
         .wr_dir     (sel_me && sel == SEL_DIR),
         .wr_pull    (sel_me && sel == SEL_PULL),
         .wdata_pins (bus_wdata[PORT_W-1:0]),
         .wdata_pull (bus_wdata[PULL_BITS-1:0]),
         .pad_sync   (pad_sync[p*PORT_W +: PORT_W]),
         .rd_sel     (sel),
         .rd_val     (rd_vals[p]),
         .pad_oe     (pad_oe[p*PORT_W +: PORT_W]),
         .pad_out    (pad_out[p*PORT_W +: PORT_W]),
         .pad_pu     (pad_pu[p*PORT_W +: PORT_W])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                drv_q <= 1'b0;
      else if (bus_we && drv_hit) drv_q <= bus_wdata[0];
   end

   assign drive_weak = drv_q;

   always_comb begin
      rd_mux = '0;
      if (port_hit) begin
         for (int p = 0; p < NUM_PORTS; p++) begin
            if (port_idx == PIDX_W'(p)) rd_mux = rd_vals[p];
         end
      end else if (drv_hit) begin
         rd_mux = {7'b0, drv_q};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rdata <= '0;
      else        rdata <= rd_mux;
   end

   // R8
   unmapped_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!port_hit && !drv_hit) |=> rdata == 8'h00);

   // R6
   pull_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (port_hit && sel == SEL_PULL) |=> (rdata >> PULL_BITS) == 8'h00);

   // R6
   drv_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drv_hit |=> rdata[7:1] == 7'h00);

   // R7
   drive_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && drv_hit) |=> drive_weak == $past(bus_wdata[0]));

endmodule

// File: tb/sim_gpio_bank.sv
module sim_gpio_bank;

   localparam int CLK_PERIOD = 10;
   localparam int NP         = 4;
   localparam int PW         = 8;
   localparam int PN         = NP * PW;
   localparam int NVEC       = 4;

   // {dir, latch, pull, pad, expected read, expected pull-up}
   localparam logic [47:0] VEC [NVEC] = '{
      48'h00_FF_00_A5_A5_00,
      48'hFF_3C_0F_C3_3C_00,
      48'h0F_5A_05_F0_FA_30,
      48'h81_80_0A_7E_FE_4C
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [7:0]    bus_addr = '0;
   logic          bus_we = 1'b0;
   logic [7:0]    bus_wdata = '0;
   logic [7:0]    rdata;
   logic [PN-1:0] pad_in = '0;
   logic [PN-1:0] pad_oe;
   logic [PN-1:0] pad_out;
   logic [PN-1:0] pad_pu;
   logic          drive_weak;

   int total = 0;
   int bad   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_bank #(.NUM_PORTS(NP), .PORT_W(PW)) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_we     (bus_we),
      .bus_wdata  (bus_wdata),
      .rdata      (rdata),
      .pad_in     (pad_in),
      .pad_oe     (pad_oe),
      .pad_out    (pad_out),
      .pad_pu     (pad_pu),
      .drive_weak (drive_weak)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      @(posedge clk);
      #1 d = rdata;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      bad++;
      total++;
      $display("FAIL watchdog: got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0]    r;
      logic [PN-1:0] snap_oe, snap_out, snap_pu;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      check("R1 oe", pad_oe, '0);
      check("R1 out", pad_out, '0);
      check("R1 pu", pad_pu, '0);
      check("R1 drive", drive_weak, 1'b0);
      check("R1 rdata", rdata, 8'h00);
      rd(8'h01, r);
      check("R1 dir readback", r, 8'h00);
      rd(8'h02, r);
      check("R1 pull readback", r, 8'h00);

      // Vector table on port 0: R2 R3 R4 R5
      for (int v = 0; v < NVEC; v++) begin
         logic [47:0] e;
         e = VEC[v];
         wr(8'h01, e[47:40]);
         wr(8'h00, e[39:32]);
         wr(8'h02, e[31:24]);
         pad_in[7:0] = e[23:16];
         repeat (3) @(negedge clk);
         rd(8'h00, r);
         check("R4 mixed read", r, e[15:8]);
         check("R2 oe", pad_oe[7:0], e[47:40]);
         check("R3 out", pad_out[7:0], e[39:32]);
         check("R5 pu pairs", pad_pu[7:0], e[7:0]);
         rd(8'h01, r);
         check("R2 dir readback", r, e[47:40]);
      end

      // R3 write to input pins stays undriven until direction flips
      wr(8'h04, 8'h77);
      check("R3 latched not driven oe", pad_oe[15:8], 8'h00);
      check("R3 latch value", pad_out[15:8], 8'h77);
      wr(8'h05, 8'hFF);
      check("R3 driven after dir", pad_oe[15:8], 8'hFF);
      check("R3 driven value", pad_out[15:8], 8'h77);

      // R6 unused pull and drive bits
      wr(8'h0A, 8'hFF);
      rd(8'h0A, r);
      check("R6 pull upper zero", r, 8'h0F);
      check("R6 pull all pins", pad_pu[23:16], 8'hFF);
      wr(8'hF0, 8'hFF);
      rd(8'hF0, r);
      check("R6 drive upper zero", r, 8'h01);

      // R7 drive strength
      check("R7 weak", drive_weak, 1'b1);
      wr(8'hF0, 8'h00);
      check("R7 strong", drive_weak, 1'b0);

      // R8 unmapped addresses
      snap_oe = pad_oe; snap_out = pad_out; snap_pu = pad_pu;
      wr(8'h03, 8'hFF);
      wr(8'h40, 8'hFF);
      wr(8'h13, 8'hFF);
      check("R8 oe unchanged", pad_oe, snap_oe);
      check("R8 out unchanged", pad_out, snap_out);
      check("R8 pu unchanged", pad_pu, snap_pu);
      rd(8'h03, r);
      check("R8 hole reads zero", r, 8'h00);
      rd(8'h40, r);
      check("R8 beyond ports zero", r, 8'h00);

      // R9 read latency
      rd(8'h05, r);
      check("R9 first read", r, 8'hFF);
      @(negedge clk);
      bus_addr = 8'h0D;
      #1 check("R9 held before edge", rdata, 8'hFF);
      @(posedge clk);
      #1 check("R9 updated after edge", rdata, 8'h00);

      // R4 synchroniser delay, port 3 input pins
      @(negedge clk);
      bus_addr = 8'h0C;
      pad_in[31:24] = 8'hC6;
      @(posedge clk);
      #1 check("R4 edge k old", rdata, 8'h00);
      @(posedge clk);
      #1 check("R4 edge k+1 old", rdata, 8'h00);
      @(posedge clk);
      #1 check("R4 edge k+2 new", rdata, 8'hC6);

      // R5 pull-up on odd pin pair with mixed direction on port 3
      wr(8'h0D, 8'h04);
      wr(8'h0E, 8'h02);
      check("R5 pair with output pin", pad_pu[31:24], 8'h08);

      // R1 reset clears everything again
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1 reset oe", pad_oe, '0);
      check("R1 reset out", pad_out, '0);
      check("R1 reset pu", pad_pu, '0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule